// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block decides, for a small 32-bit core with banked processor modes, when an exception is taken and what state the core moves into. Each cycle it looks at seven kinds of pending exception (reset, undefined instruction, software interrupt, prefetch abort, data abort, IRQ and FIQ). It drops any interrupt that the current status word masks and picks one winner by fixed priority. For the winner it presents the vector address and the link value to write, and on the next clock edge it moves the status word into the target mode. The old status word is kept in that mode's saved-status copy.

On an exception return it gives the resume address. This is the link value minus a correction that depends on the kind of exception that last entered the current mode. On the same edge it copies the saved status back into the live status word. The core can also load the status word directly through a plain write port. The block drives the select lines for the banked stack pointer and link register, and a separate line that swaps in the FIQ-private upper general registers. The register storage for those lines sits outside the block.

Top module: `exc_ctrl`

## Requirements
- R1: After reset the status word reads 0x000000D3: mode field (bits 4:0) is supervisor 10011, bit 7 (I) is 1, bit 6 (F) is 1, bit 5 (T) is 0. The saved-status output reads 0 and the bank select reads 3.
- R2: Request bit n of `req_i` stands for kind code n: 0 reset, 1 undefined, 2 software interrupt, 3 prefetch abort, 4 data abort, 6 IRQ, 7 FIQ. When several eligible requests are pending at once, `kind_o` names the highest-priority one. The order from highest to lowest is reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R3: `take_o` is high exactly when at least one eligible request is pending. An IRQ request is not eligible while status bit 7 is 1, an FIQ request is not eligible while status bit 6 is 1, and request bit 5 is never eligible.
- R4: While `take_o` is high, `vec_o` equals VEC_BASE + 4 × kind code. The reserved slot at offset 0x14 is never produced.
- R5: While `take_o` is high, `link_o` equals `pc_i` + 4.
- R6: After an entry edge, the status word keeps the old word except for four fields. The mode field becomes the target mode: reset and software interrupt go to supervisor 10011, undefined to 11011, both aborts to 10111, IRQ to 10010 and FIQ to 10001. Bit 7 is set to 1. Bit 6 is set to 1 for FIQ and reset and otherwise keeps its value. Bit 5 is cleared.
- R7: On an entry edge, the status word from before the edge is stored as the target mode's saved status. Once the mode has changed, `spsr_o` shows the saved status of the current mode, and shows 0 in user (10000), system (11111) or any unrecognised mode.
- R8: `ret_ok_o` is high when `ret_i` is high, no entry is taken that cycle, and the current mode has a saved status. Then `resume_o` equals `lr_i` minus a correction set by the kind that last entered the current mode: 0 for reset, undefined and software interrupt, 4 for IRQ, FIQ and prefetch abort, 8 for data abort. On that edge the saved status is copied into the status word.
- R9: A return request in user, system or an unrecognised mode has no effect: `ret_ok_o` stays low and the status word is unchanged.
- R10: `bank_o` encodes the active stack/link bank: 0 user/system/unrecognised, 1 FIQ, 2 IRQ, 3 supervisor, 4 abort, 5 undefined. `fiq_bank_o` is high only in FIQ mode.
- R11: A status write (`st_wr_i`) loads `st_wdata_i` into the status word only when no entry and no return happen in the same cycle. Entry outranks return, and return outranks write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Pending exception requests, bit index = kind code |
| pc_i | input | ADDR_W | Address of the instruction at which the exception is taken |
| ret_i | input | 1 | Exception-return request |
| lr_i | input | ADDR_W | Link register value of the current mode |
| st_wr_i | input | 1 | Direct status-word write strobe |
| st_wdata_i | input | SR_W | Status word to load |
| take_o | output | 1 | An exception is taken this cycle |
| kind_o | output | 3 | Kind code of the selected exception |
| vec_o | output | ADDR_W | Vector address of the selected exception |
| link_o | output | ADDR_W | Value to write to the entered mode's link register |
| ret_ok_o | output | 1 | The return request is accepted this cycle |
| resume_o | output | ADDR_W | Address at which execution resumes after return |
| cpsr_o | output | SR_W | Current status word |
| spsr_o | output | SR_W | Saved status of the current mode (0 if none) |
| bank_o | output | 3 | Stack pointer / link register bank select |
| fiq_bank_o | output | 1 | Select for the FIQ-private upper general registers |

## Verification
The bench builds the block with VEC_BASE set to 0xFFFF0000 and leaves the widths at 32 bits. A wrong offset or a vector computed without the base then shows at once in the upper address half. A wrapping or truncated addition would corrupt the high bits as well. Directed sequences walk nested IRQ then FIQ entry and back. Random status writes put the core in every mode, including unrecognised ones. This brings every pairing of mask bits, return correction and bank select into reach of the reference model.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [2:0] {
    K_RST  = 3'd0,
    K_UND  = 3'd1,
    K_SWI  = 3'd2,
    K_PABT = 3'd3,
    K_DABT = 3'd4,
    K_RSV  = 3'd5,
    K_IRQ  = 3'd6,
    K_FIQ  = 3'd7
  } exc_kind_e;

  typedef enum logic [2:0] {
    B_USR = 3'd0,
    B_FIQ = 3'd1,
    B_IRQ = 3'd2,
    B_SVC = 3'd3,
    B_ABT = 3'd4,
    B_UND = 3'd5
  } bank_e;

  localparam int unsigned NUM_KIND = 8;
  localparam int unsigned NUM_BANK = 6;
  localparam int unsigned NUM_PRIO = 7;
  localparam int unsigned MODE_W   = 5;
  localparam int unsigned BIT_I    = 7;
  localparam int unsigned BIT_F    = 6;
  localparam int unsigned BIT_T    = 5;

  localparam logic [MODE_W-1:0] M_USR = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;
  localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

  // Highest priority first.
  localparam exc_kind_e PRIO_ORDER [NUM_PRIO] =
    '{K_RST, K_DABT, K_FIQ, K_IRQ, K_PABT, K_UND, K_SWI};

  function automatic logic [MODE_W-1:0] mode_of_kind(input exc_kind_e k);
    case (k)
      K_UND:          return M_UND;
      K_PABT, K_DABT: return M_ABT;
      K_IRQ:          return M_IRQ;
      K_FIQ:          return M_FIQ;
      default:        return M_SVC;
    endcase
  endfunction

  function automatic bank_e bank_of_mode(input logic [MODE_W-1:0] m);
    case (m)
      M_FIQ:   return B_FIQ;
      M_IRQ:   return B_IRQ;
      M_SVC:   return B_SVC;
      M_ABT:   return B_ABT;
      M_UND:   return B_UND;
      default: return B_USR;
    endcase
  endfunction

  // Byte distance between the stored link value and the resume point.
  function automatic logic [3:0] ret_adjust(input exc_kind_e k);
    case (k)
      K_IRQ, K_FIQ, K_PABT: return 4'd4;
      K_DABT:               return 4'd8;
      default:              return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic [NUM_KIND-1:0] req_i,
  input  logic                i_mask_i,
  input  logic                f_mask_i,
  output logic                take_o,
  output exc_kind_e           kind_o
);

  logic [NUM_KIND-1:0] elig;

  always_comb begin
    elig        = req_i;
    elig[K_RSV] = 1'b0;
    if (i_mask_i) elig[K_IRQ] = 1'b0;
    if (f_mask_i) elig[K_FIQ] = 1'b0;
  end

  assign take_o = |elig;

  // Walk from lowest to highest priority so the last hit wins.
  always_comb begin
    kind_o = K_RST;
    for (int i = NUM_PRIO - 1; i >= 0; i--) begin
      if (elig[PRIO_ORDER[i]]) kind_o = PRIO_ORDER[i];
    end
  end

endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 32,
  parameter int unsigned       SR_W     = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  exc_kind_e         kind_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [SR_W-1:0]   sr_i,
  output logic [ADDR_W-1:0] vec_o,
  output logic [ADDR_W-1:0] link_o,
  output logic [SR_W-1:0]   sr_o,
  output bank_e             bank_o
);

  localparam int unsigned VEC_SHIFT = 2;
  localparam logic [ADDR_W-1:0] NEXT_STEP = ADDR_W'(1 << VEC_SHIFT);

  logic [MODE_W-1:0] tgt_mode;

  assign tgt_mode = mode_of_kind(kind_i);
  assign vec_o    = VEC_BASE + (ADDR_W'(kind_i) << VEC_SHIFT);
  assign link_o   = pc_i + NEXT_STEP;
  assign bank_o   = bank_of_mode(tgt_mode);

  always_comb begin
    sr_o             = sr_i;
    sr_o[MODE_W-1:0] = tgt_mode;
    sr_o[BIT_I]      = 1'b1;
    if (kind_i == K_FIQ || kind_i == K_RST) sr_o[BIT_F] = 1'b1;
    sr_o[BIT_T]      = 1'b0;
  end

endmodule

// File: rtl/exc_bank_sel.sv
module exc_bank_sel
  import exc_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output bank_e             bank_o,
  output logic              fiq_bank_o,
  output logic              has_saved_o
);

  assign bank_o      = bank_of_mode(mode_i);
  assign fiq_bank_o  = (bank_o == B_FIQ);
  assign has_saved_o = (bank_o != B_USR);

endmodule

// File: rtl/exc_status_regs.sv
module exc_status_regs
  import exc_pkg::*;
#(
  parameter int unsigned SR_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            entry_i,
  input  exc_kind_e       kind_i,
  input  bank_e           tgt_bank_i,
  input  logic [SR_W-1:0] entry_sr_i,
  input  logic            return_i,
  input  logic            write_i,
  input  logic [SR_W-1:0] wdata_i,
  input  bank_e           cur_bank_i,
  output logic [SR_W-1:0] cpsr_o,
  output logic [SR_W-1:0] spsr_o,
  output exc_kind_e       cur_kind_o
);

  localparam logic [SR_W-1:0] RESET_SR = SR_W'({2'b11, 1'b0, M_SVC});

  logic [SR_W-1:0] cpsr_q;
  logic [SR_W-1:0] spsr_q [1:NUM_BANK-1];
  exc_kind_e       ek_q   [1:NUM_BANK-1];

  // Saved-status bank read for the current mode.
  always_comb begin
    spsr_o     = '0;
    cur_kind_o = K_RST;
    for (int b = 1; b < NUM_BANK; b++) begin
      if (cur_bank_i == bank_e'(b)) begin
        spsr_o     = spsr_q[b];
        cur_kind_o = ek_q[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpsr_q <= RESET_SR;
    end else if (entry_i) begin
      cpsr_q <= entry_sr_i;
    end else if (return_i) begin
      cpsr_q <= spsr_o;
    end else if (write_i) begin
      cpsr_q <= wdata_i;
    end
  end

  for (genvar b = 1; b < NUM_BANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        spsr_q[b] <= '0;
        ek_q[b]   <= K_RST;
      end else if (entry_i && tgt_bank_i == bank_e'(b)) begin
        spsr_q[b] <= cpsr_q;
        ek_q[b]   <= kind_i;
      end
    end
  end

  assign cpsr_o = cpsr_q;

endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 32,
  parameter int unsigned       SR_W     = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_KIND-1:0] req_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic                ret_i,
  input  logic [ADDR_W-1:0]   lr_i,
  input  logic                st_wr_i,
  input  logic [SR_W-1:0]     st_wdata_i,
  output logic                take_o,
  output logic [2:0]          kind_o,
  output logic [ADDR_W-1:0]   vec_o,
  output logic [ADDR_W-1:0]   link_o,
  output logic                ret_ok_o,
  output logic [ADDR_W-1:0]   resume_o,
  output logic [SR_W-1:0]     cpsr_o,
  output logic [SR_W-1:0]     spsr_o,
  output logic [2:0]          bank_o,
  output logic                fiq_bank_o
);

  logic            entry_ev;
  logic            return_ev;
  logic            write_ev;
  logic            has_saved;
  exc_kind_e       sel_kind;
  exc_kind_e       cur_kind;
  bank_e           cur_bank;
  bank_e           tgt_bank;
  logic [SR_W-1:0] cpsr;
  logic [SR_W-1:0] spsr_cur;
  logic [SR_W-1:0] entry_sr;

  exc_arbiter u_arb (
    .req_i    (req_i),
    .i_mask_i (cpsr[BIT_I]),
    .f_mask_i (cpsr[BIT_F]),
    .take_o   (entry_ev),
    .kind_o   (sel_kind)
  );

  exc_entry_calc #(
    .ADDR_W   (ADDR_W),
    .SR_W     (SR_W),
    .VEC_BASE (VEC_BASE)
  ) u_entry (
    .kind_i (sel_kind),
    .pc_i   (pc_i),
    .sr_i   (cpsr),
    .vec_o  (vec_o),
    .link_o (link_o),
    .sr_o   (entry_sr),
    .bank_o (tgt_bank)
  );

  exc_bank_sel u_bank (
    .mode_i      (cpsr[MODE_W-1:0]),
    .bank_o      (cur_bank),
    .fiq_bank_o  (fiq_bank_o),
    .has_saved_o (has_saved)
  );

  assign return_ev = ret_i & ~entry_ev & has_saved;
  assign write_ev  = st_wr_i & ~entry_ev & ~return_ev;

  exc_status_regs #(
    .SR_W (SR_W)
  ) u_sr (
    .clk        (clk),
    .rst_n      (rst_n),
    .entry_i    (entry_ev),
    .kind_i     (sel_kind),
    .tgt_bank_i (tgt_bank),
    .entry_sr_i (entry_sr),
    .return_i   (return_ev),
    .write_i    (write_ev),
    .wdata_i    (st_wdata_i),
    .cur_bank_i (cur_bank),
    .cpsr_o     (cpsr),
    .spsr_o     (spsr_cur),
    .cur_kind_o (cur_kind)
  );

  assign take_o   = entry_ev;
  assign kind_o   = sel_kind;
  assign ret_ok_o = return_ev;
  assign resume_o = lr_i - ADDR_W'(ret_adjust(cur_kind));
  assign cpsr_o   = cpsr;
  assign spsr_o   = spsr_cur;
  assign bank_o   = cur_bank;

endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int unsigned SR_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      req_i,
  input logic            take_o,
  input logic [2:0]      kind_o,
  input logic            ret_ok_o,
  input logic            return_ev,
  input logic            write_ev,
  input logic [SR_W-1:0] st_wdata_i,
  input logic [SR_W-1:0] cpsr_o,
  input logic [SR_W-1:0] spsr_o,
  input logic [2:0]      bank_o,
  input logic            fiq_bank_o
);

  // R2
  reset_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && req_i[0]) |-> kind_o == 3'd0);

  // R3
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && kind_o == 3'd6) |-> !cpsr_o[7]);

  // R3
  fiq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && kind_o == 3'd7) |-> !cpsr_o[6]);

  // R4
  rsv_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> kind_o != 3'd5);

  // R6
  entry_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> cpsr_o[7]);

  // R7
  save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |=> spsr_o == $past(cpsr_o));

  // R8
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    return_ev |=> cpsr_o == $past(spsr_o));

  // R9
  user_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_o == 3'd0) |-> !ret_ok_o);

  // R10
  fiq_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_bank_o |-> bank_o == 3'd1);

  // R11
  write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    write_ev |=> cpsr_o == $past(st_wdata_i));

endmodule

bind exc_ctrl exc_ctrl_chk #(.SR_W(SR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .take_o     (take_o),
  .kind_o     (kind_o),
  .ret_ok_o   (ret_ok_o),
  .return_ev  (return_ev),
  .write_ev   (write_ev),
  .st_wdata_i (st_wdata_i),
  .cpsr_o     (cpsr_o),
  .spsr_o     (spsr_o),
  .bank_o     (bank_o),
  .fiq_bank_o (fiq_bank_o)
);

// File: tb/exc_ctrl_tb.sv
module exc_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'hFFFF_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req_i = '0;
  logic [31:0] pc_i = '0;
  logic        ret_i = 1'b0;
  logic [31:0] lr_i = '0;
  logic        st_wr_i = 1'b0;
  logic [31:0] st_wdata_i = '0;
  logic        take_o;
  logic [2:0]  kind_o;
  logic [31:0] vec_o;
  logic [31:0] link_o;
  logic        ret_ok_o;
  logic [31:0] resume_o;
  logic [31:0] cpsr_o;
  logic [31:0] spsr_o;
  logic [2:0]  bank_o;
  logic        fiq_bank_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_ctrl #(.VEC_BASE(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .pc_i(pc_i), .ret_i(ret_i),
    .lr_i(lr_i), .st_wr_i(st_wr_i), .st_wdata_i(st_wdata_i),
    .take_o(take_o), .kind_o(kind_o), .vec_o(vec_o), .link_o(link_o),
    .ret_ok_o(ret_ok_o), .resume_o(resume_o), .cpsr_o(cpsr_o),
    .spsr_o(spsr_o), .bank_o(bank_o), .fiq_bank_o(fiq_bank_o)
  );

  // Reference model state
  logic [31:0] m_cpsr;
  logic [31:0] m_sp [6];
  int          m_ek [6];

  function automatic int mbank(input logic [4:0] m);
    case (m)
      5'h11: return 1;
      5'h12: return 2;
      5'h13: return 3;
      5'h17: return 4;
      5'h1B: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [4:0] mmode(input int k);
    if (k == 1) return 5'h1B;
    if (k == 3 || k == 4) return 5'h17;
    if (k == 6) return 5'h12;
    if (k == 7) return 5'h11;
    return 5'h13;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_cpsr = 32'h0000_00D3;
    for (int i = 0; i < 6; i++) begin
      m_sp[i] = '0;
      m_ek[i] = 0;
    end
  endtask

  task automatic step(input logic [7:0] rq, input logic [31:0] pc, input logic rt,
                      input logic [31:0] lr, input logic wr, input logic [31:0] wd);
    int order [7] = '{0, 4, 7, 6, 3, 1, 2};
    int pick;
    int cb;
    int off;
    bit rok;
    logic [31:0] nsr;
    @(negedge clk);
    req_i = rq; pc_i = pc; ret_i = rt; lr_i = lr; st_wr_i = wr; st_wdata_i = wd;
    #1;
    pick = -1;
    foreach (order[i]) begin
      int k = order[i];
      if (pick < 0 && rq[k] && k != 5 && !(k == 6 && m_cpsr[7]) && !(k == 7 && m_cpsr[6]))
        pick = k;
    end
    cb  = mbank(m_cpsr[4:0]);
    rok = rt && pick < 0 && cb != 0;
    off = (m_ek[cb] == 3 || m_ek[cb] == 6 || m_ek[cb] == 7) ? 4 : (m_ek[cb] == 4 ? 8 : 0);
    chk("R3 take", {31'd0, take_o}, {31'd0, pick >= 0});
    if (pick >= 0) begin
      chk("R2 kind", {29'd0, kind_o}, 32'(pick));
      chk("R4 vector", vec_o, BASE + 32'(pick * 4));
      chk("R5 link", link_o, pc + 32'd4);
    end
    chk("R9 ret_ok", {31'd0, ret_ok_o}, {31'd0, rok});
    if (rok) chk("R8 resume", resume_o, lr - 32'(off));
    chk("R6 status", cpsr_o, m_cpsr);
    chk("R7 saved", spsr_o, cb == 0 ? 32'd0 : m_sp[cb]);
    chk("R10 bank", {29'd0, bank_o}, 32'(cb));
    chk("R10 fiq_bank", {31'd0, fiq_bank_o}, {31'd0, cb == 1});
    @(posedge clk);
    if (pick >= 0) begin
      int tb = mbank(mmode(pick));
      nsr = m_cpsr;
      nsr[4:0] = mmode(pick);
      nsr[7] = 1'b1;
      if (pick == 7 || pick == 0) nsr[6] = 1'b1;
      nsr[5] = 1'b0;
      m_sp[tb] = m_cpsr;
      m_ek[tb] = pick;
      m_cpsr = nsr;
    end else if (rok) begin
      m_cpsr = m_sp[cb];
    end else if (wr) begin
      m_cpsr = wd;
    end
  endtask

  task automatic idle();
    step(8'h00, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [4:0] modes [8] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h05};
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 status", cpsr_o, 32'h0000_00D3);
    chk("R1 saved", spsr_o, 32'h0);
    chk("R1 bank", {29'd0, bank_o}, 32'd3);
    idle();
    // software interrupt from supervisor
    step(8'h04, 32'h0000_1000, 1'b0, 32'h0, 1'b0, 32'h0);
    // R11: status write to user mode, interrupts enabled
    step(8'h00, 32'h0, 1'b0, 32'h0, 1'b1, 32'h6000_0010);
    @(negedge clk);
    #1;
    chk("R11 write", cpsr_o, 32'h6000_0010);
    // R9: return in user mode ignored
    step(8'h00, 32'h0, 1'b1, 32'h0000_2000, 1'b0, 32'h0);
    // R3: reserved bit alone is ignored
    step(8'h20, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
    // R2: IRQ beats undefined
    step(8'h42, 32'h0000_3000, 1'b0, 32'h0, 1'b0, 32'h0);
    // R3: IRQ masked now, FIQ still taken
    step(8'h40, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
    step(8'hC0, 32'h0000_3100, 1'b0, 32'h0, 1'b0, 32'h0);
    // R8: return from FIQ then from IRQ
    step(8'h00, 32'h0, 1'b1, 32'h0000_3104, 1'b0, 32'h0);
    step(8'h00, 32'h0, 1'b1, 32'h0000_3004, 1'b0, 32'h0);
    // R11: entry outranks write
    step(8'h08, 32'h0000_4000, 1'b0, 32'h0, 1'b1, 32'h0000_001F);
    // R8: data abort resume offset 8, entry outranks return
    step(8'h10, 32'h0000_5000, 1'b1, 32'h0, 1'b0, 32'h0);
    step(8'h00, 32'h0, 1'b1, 32'h0000_5008, 1'b0, 32'h0);
    // R2: full-priority sweep
    step(8'hDF, 32'h0000_6000, 1'b0, 32'h0, 1'b0, 32'h0);
    step(8'hDE, 32'h0000_6000, 1'b0, 32'h0, 1'b1, 32'h0);
    step(8'h00, 32'h0, 1'b0, 32'h0, 1'b1, 32'h0000_0010);
    step(8'hCE, 32'h0000_7000, 1'b0, 32'h0, 1'b0, 32'h0);
    // random traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [31:0] wd;
      logic [7:0]  rq;
      wd = $urandom;
      wd[4:0] = modes[$urandom_range(0, 7)];
      rq = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00;
      step(rq, $urandom, ($urandom_range(0, 2) == 0), $urandom,
           ($urandom_range(0, 3) == 0), wd);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule